// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. Two address strobes are active low and work independently. When either one is sampled low on a rising clock edge, the block captures a full base address and starts a new burst at beat zero.

After the capture, every cycle in which the active-low advance input is sampled low steps a two-bit beat counter. The two low address bits are then formed from the captured low bits and the beat count. A static mode input chooses how they are combined:

- **Interleaved order:** the captured low bits XOR the beat count.
- **Linear order:** the captured low bits plus the beat count, modulo four.

The upper address bits stay exactly as captured. When advance is high, the burst pauses. A freeze input holds all state, which stands in for clock-enable or sleep conditions.

A small state machine controls the sequence. It has two states:

- **ST_IDLE:** the state after reset, before any address has been captured.
- **ST_RUN:** a burst base is held.

It has five named transitions:

- **LOAD_FIRST:** ST_IDLE to ST_RUN, taken on a strobe.
- **RESTART:** ST_RUN to ST_RUN, taken on a strobe. It captures a new base and clears the beat count.
- **ADVANCE:** ST_RUN to ST_RUN, taken when advance is low. It increments the beat count.
- **SUSPEND:** stays in the current state with the beat count held, when there is no strobe and advance is high.
- **FREEZE:** any state to itself, with everything held.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the state is ST_IDLE, the beat count is zero, and `cur_addr` and `burst_ofs` read zero.
- R2: When `proc_strobe_n` or `ctrl_strobe_n` (or both) is low at a rising edge and `freeze` is low, the next cycle shows `cur_addr` equal to the captured `addr_in` with the beat count at zero.
- R3: In ST_RUN, with no strobe and `adv_n` low, each rising edge increments the beat count by one, modulo four.
- R4: With `interleave` = 0 (linear order), `burst_ofs` equals (captured low bits + beat) mod 4. For a start of 01 the order is 01, 10, 11, 00.
- R5: With no strobe and `adv_n` high, the beat count and the captured base hold, so `cur_addr` is unchanged.
- R6: `cur_addr[AW-1:2]` changes only on a capture; advancing never alters it.
- R7: With `interleave` = 1 (interleaved order), `burst_offset` equals the captured low bits XOR beat. For a start of 01 the order is 01, 00, 11, 10.
- R8: After four advances the burst returns to its starting address.
- R9: A strobe during a burst restarts it from the new base and takes priority over a simultaneous advance.
- R10: In ST_IDLE an advance has no effect and `cur_addr` stays zero.
- R11: While `freeze` is high, strobes and advance are ignored and `cur_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proc_strobe_n | input | 1 | First address strobe, active low |
| ctrl_strobe_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| freeze | input | 1 | Holds all state while high |
| addr_in | input | AW | Base address to capture |
| burst_ofs | output | 2 | Current two-bit burst offset |
| cur_addr | output | AW | Current full address |

## Verification
The bench walks a linear burst through wrap-around with a pause in the middle. A design that stepped while suspended, or that failed to return to the start after four beats, would show an offset one position off.

It runs an interleaved burst starting at an odd offset. There, an adder in place of the XOR produces 10 instead of 00 on the second beat.

It also targets three priority cases:

- A strobe that arrives together with advance in mid-burst. A design that favoured advance would continue the old burst.
- A strobe while frozen. A design that ignored freeze would jump to the new base.
- Advance before any capture. Without the idle guard, the offset would leave zero.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        TR_NONE,
        TR_LOAD_FIRST,
        TR_RESTART,
        TR_ADVANCE,
        TR_SUSPEND,
        TR_FREEZE
    } seq_trans_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          freeze,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base_q,
    output beat_t         beat_q,
    output seq_state_e    state_q
);

    seq_state_e    state_d;
    seq_trans_e    trans;
    beat_t         beat_d;
    logic [AW-1:0] base_d;

    // Transition selection: freeze over load over advance.
    always_comb begin
        state_d = state_q;
        trans   = TR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (freeze) begin
                    trans = TR_FREEZE;
                end else if (load) begin
                    trans   = TR_LOAD_FIRST;
                    state_d = ST_RUN;
                end else begin
                    trans = TR_SUSPEND;
                end
            end
            ST_RUN: begin
                if (freeze) begin
                    trans = TR_FREEZE;
                end else if (load) begin
                    trans = TR_RESTART;
                end else if (step) begin
                    trans = TR_ADVANCE;
                end else begin
                    trans = TR_SUSPEND;
                end
            end
            default: begin
                trans   = TR_NONE;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath outputs of each transition.
    always_comb begin
        beat_d = beat_q;
        base_d = base_q;
        unique case (trans)
            TR_LOAD_FIRST, TR_RESTART: begin
                beat_d = '0;
                base_d = addr_in;
            end
            TR_ADVANCE: begin
                beat_d = beat_q + beat_t'(1);
            end
            default: begin
                beat_d = beat_q;
                base_d = base_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
        end
    end

endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
    import burst_seq_pkg::*;
(
    input  beat_t start_lo,
    input  beat_t beat,
    input  logic  interleave,
    output beat_t ofs
);

    beat_t lin_ofs;
    beat_t ilv_ofs;

    always_comb begin
        lin_ofs = start_lo + beat;
        ilv_ofs = start_lo ^ beat;
        ofs     = interleave ? ilv_ofs : lin_ofs;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          adv_n,
    input  logic          interleave,
    input  logic          freeze,
    input  logic [AW-1:0] addr_in,
    output logic [1:0]    burst_ofs,
    output logic [AW-1:0] cur_addr
);

    localparam int UPPER_W = AW - BEAT_W;

    logic          load;
    logic          step;
    logic [AW-1:0] base_q;
    beat_t         beat_q;
    seq_state_e    state_q;
    beat_t         ofs;

    assign load = ~proc_strobe_n | ~ctrl_strobe_n;
    assign step = ~adv_n;

    burst_seq_fsm #(.AW(AW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .freeze  (freeze),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q),
        .state_q (state_q)
    );

    burst_seq_order u_order (
        .start_lo   (base_q[BEAT_W-1:0]),
        .beat       (beat_q),
        .interleave (interleave),
        .ofs        (ofs)
    );

    assign burst_ofs = ofs;
    assign cur_addr  = {base_q[AW-1:AW-UPPER_W], ofs};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          proc_strobe_n,
    input logic          ctrl_strobe_n,
    input logic          adv_n,
    input logic          freeze,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] cur_addr,
    input logic [AW-1:0] base_q,
    input beat_t         beat_q,
    input seq_state_e    state_q
);

    logic ld;
    assign ld = ~proc_strobe_n | ~ctrl_strobe_n;

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !freeze) |=> (cur_addr[AW-1:2] == $past(addr_in[AW-1:2])) && (beat_q == 2'd0));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !adv_n && !ld && !freeze) |=> (beat_q == $past(beat_q) + 2'd1));

    a_r5_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && !ld && !freeze) |=> ($stable(beat_q) && $stable(base_q)));

    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld || freeze) |=> $stable(cur_addr[AW-1:2]));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (beat_q == 2'd0));

    a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(beat_q) && $stable(base_q) && $stable(state_q)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .freeze        (freeze),
    .addr_in       (addr_in),
    .cur_addr      (cur_addr),
    .base_q        (base_q),
    .beat_q        (beat_q),
    .state_q       (state_q)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ps_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ilv = 1'b0;
    logic          frz = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    burst_ofs;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference state kept from the requirements.
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .proc_strobe_n (ps_n),
        .ctrl_strobe_n (cs_n),
        .adv_n         (adv_n),
        .interleave    (ilv),
        .freeze        (frz),
        .addr_in       (addr),
        .burst_ofs     (burst_ofs),
        .cur_addr      (cur_addr)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] o;
        o = ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], o};
    endfunction

    task automatic step(input logic p, input logic c, input logic a, input logic mode,
                        input logic f, input logic [AW-1:0] ad, input string tag);
        @(negedge clk);
        ps_n = p; cs_n = c; adv_n = a; ilv = mode; frz = f; addr = ad;
        @(posedge clk);
        if (!f) begin
            if (!p || !c) begin
                m_base = ad; m_beat = 2'd0; m_run = 1'b1;
            end else if (m_run && !a) begin
                m_beat = m_beat + 2'd1;
            end
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (cur_addr !== e || burst_ofs !== e[1:0]) begin
                    errors++;
                    $display("FAIL %s: cur_addr=%h ofs=%b expected cur_addr=%h ofs=%b",
                             t, cur_addr, burst_ofs, e, e[1:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cur_addr !== '0 || burst_ofs !== 2'b00) begin
            errors++;
            $display("FAIL R1: cur_addr=%h ofs=%b expected 0 00", cur_addr, burst_ofs);
        end
        rst_n = 1'b1;

        step(1, 1, 0, 0, 0, 18'h00000, "R10 advance while idle");
        step(0, 1, 1, 0, 0, 18'h12345, "R2 first-strobe capture");
        step(1, 1, 0, 0, 0, 18'h00000, "R4 linear beat1");
        step(1, 1, 0, 0, 0, 18'h00000, "R4 linear beat2");
        step(1, 1, 0, 0, 0, 18'h00000, "R4 linear beat3");
        step(1, 1, 1, 0, 0, 18'h3FFFF, "R5 suspend");
        step(1, 1, 0, 0, 0, 18'h00000, "R8 linear wrap");
        step(1, 0, 1, 1, 0, 18'h0ABC5, "R2 second-strobe capture");
        step(1, 1, 0, 1, 0, 18'h00000, "R7 interleaved beat1");
        step(1, 1, 0, 1, 0, 18'h00000, "R7 interleaved beat2");
        step(1, 1, 0, 1, 0, 18'h00000, "R7 interleaved beat3");
        step(1, 1, 0, 1, 0, 18'h00000, "R8 interleaved wrap");
        step(1, 1, 0, 1, 0, 18'h00000, "R6 upper bits fixed");
        step(0, 1, 0, 1, 0, 18'h3FFFE, "R9 restart beats advance");
        step(1, 1, 0, 1, 0, 18'h00000, "R7 after restart");
        step(1, 0, 0, 1, 1, 18'h00003, "R11 freeze ignores strobe");
        step(1, 1, 0, 1, 0, 18'h00000, "R3 step after freeze");
        step(0, 0, 1, 0, 0, 18'h0000B, "R2 both strobes");
        step(1, 1, 0, 0, 0, 18'h00000, "R4 linear from 11");
        step(1, 1, 0, 0, 0, 18'h00000, "R3 step");
        step(1, 1, 1, 0, 0, 18'h00000, "R6 hold upper");

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule